// File: doc/BRIEF.md
# MDIO Management Poller for Five PHYs

This block is a self-running management master on a two-wire MDC/MDIO bus serving five external PHY transceivers. After reset it brings the PHYs up one after another. For each PHY it first writes the switch's own abilities into the advertisement register, then restarts auto-negotiation through the control register. After that it loops over the PHYs without end. On every visit it reads the basic status register and the link-partner ability register.

From each pair of reads it resolves four facts for that port: link good, 100 Mb/s, full duplex, and pause flow control. It publishes them as two packed 16-bit status words that the rest of the switch reads directly. A strap input holds the whole sequence off. The PHYs sit at consecutive bus addresses starting at 8, so port 0 is address 8 and port 4 is address 12.

Top module: `mgmt_phy_poller`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, both status words read 0, `mdio_oe` is low and `mdio_o` is high.
- R2: While `poll_en` is low after reset, no MDIO frame starts. `mdio_oe` stays low and both status words stay 0.
- R3: Once `poll_en` is high, ports are initialised in ascending order, PHY address 8 first. Each port receives two frames in this order: a write of `ADV_WORD` to register 4, then a write of 16'h1200 to register 0 (restart plus auto-negotiation enable, bits 12 and 9).
- R4: After the last initialisation frame, the block reads register 1 and then register 5 from each PHY in ascending address order. When PHY 12 is done it wraps back to PHY 8, with no end.
- R5: Every frame is 64 MDC bits, most significant bit first, in this order:
  - 32 ones;
  - start code 01;
  - opcode, 01 for write or 10 for read;
  - 5-bit PHY address;
  - 5-bit register address;
  - a 2-bit turnaround, driven as 10 on writes;
  - 16 data bits.
  On reads, `mdio_oe` is low from the first turnaround bit to the end of the frame.
- R6: MDC has a high time and a low time of `HALF_DIV` clock cycles each. `mdio_o` and `mdio_oe` change only at MDC falling edges. Read data is sampled at MDC rising edges.
- R7: The link of port p is bit 2 of PHY p's register 1. It is reported at bit 8+p of `pause_link`. When link is down, speed, duplex and pause for that port are all 0.
- R8: With link up, speed and duplex resolve to the best mode present in both `ADV_WORD` and register 5. The mode bits are bit 8 = 100 full, bit 7 = 100 half, bit 6 = 10 full and bit 5 = 10 half, and the order of preference is that same order. With no common mode, speed and duplex are 0.
- R9: Pause (bit p of `pause_link`) is 1 only when link is up, duplex resolves to full, and bit 10 is set in both `ADV_WORD` and register 5.
- R10: Status word layout:
  - `speed_duplex` carries 100 Mb/s in bits [4:0] and full duplex in bits [12:8];
  - `pause_link` carries pause in bits [4:0] and link in bits [12:8];
  - bit p of each field is port p;
  - all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Strap: 1 lets the init and poll sequence run |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven toward the PHYs |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data returned from the pad |
| pause_link | output | 16 | [4:0] pause per port, [12:8] link per port |
| speed_duplex | output | 16 | [4:0] 100 Mb/s per port, [12:8] full duplex per port |

## Verification
The bench builds the block with `HALF_DIV = 2`, so an MDC period is four system clocks and a 64-bit frame takes about 260 cycles. At that rate the full initialisation and six complete polling rounds fit in a short run. This lets the bench change the PHY register contents between rounds and watch every resolution case (each speed/duplex priority level, no common mode, half-duplex pause suppression, link loss) reach the status words. The default `ADV_WORD` advertises all four modes and pause, so every partner combination is decided by the partner's register alone.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;

  typedef enum logic [1:0] {
    MD_OP_WRITE = 2'b01,
    MD_OP_READ  = 2'b10
  } md_op_e;

  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned TA_POS    = 46;  // bit index of first turnaround bit
  localparam int unsigned DATA_POS  = 48;  // bit index of first data bit

  localparam logic [4:0]  REG_CTRL = 5'd0;
  localparam logic [4:0]  REG_STAT = 5'd1;
  localparam logic [4:0]  REG_ADV  = 5'd4;
  localparam logic [4:0]  REG_LPA  = 5'd5;
  localparam logic [15:0] ANEG_RESTART = 16'h1200;

  typedef struct packed {
    md_op_e      op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } md_cmd_t;

  typedef struct packed {
    logic link;
    logic fast;
    logic full;
    logic pause;
  } port_res_t;

  function automatic logic [63:0] md_frame(md_cmd_t c);
    logic [1:0]  ta;
    logic [15:0] d;
    ta = (c.op == MD_OP_WRITE) ? 2'b10 : 2'b11;
    d  = (c.op == MD_OP_WRITE) ? c.wdata : 16'hFFFF;
    return {32'hFFFF_FFFF, 2'b01, c.op, c.phy, c.regad, ta, d};
  endfunction

  function automatic port_res_t md_resolve(logic [15:0] adv, logic link_up,
                                           logic [15:0] lpa);
    logic [3:0] common;
    port_res_t  r;
    common = adv[8:5] & lpa[8:5];  // [3]=100F [2]=100H [1]=10F [0]=10H
    r      = '0;
    r.link = link_up;
    if (link_up) begin
      if (common[3]) begin
        r.fast = 1'b1;
        r.full = 1'b1;
      end else if (common[2]) begin
        r.fast = 1'b1;
      end else if (common[1]) begin
        r.full = 1'b1;
      end
      r.pause = r.full & adv[10] & lpa[10];
    end
    return r;
  endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int unsigned HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  always_comb begin
    term  = (cnt_q == TERM);
    cnt_d = term ? '0 : cnt_q + CW'(1);
    mdc_d = term ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term & ~mdc_q;
  assign fall_tick = term & mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        start,
  input  md_cmd_t     cmd,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [6:0] LAST_CNT = 7'(FRAME_LEN);
  localparam logic [6:0] TA_CNT   = 7'(TA_POS);
  localparam logic [6:0] RD_CNT   = 7'(DATA_POS + 1);

  logic        busy_q, busy_d;
  logic        done_q, done_d;
  logic        rd_q, rd_d;
  logic [6:0]  cnt_q, cnt_d;
  logic [63:0] sh_q, sh_d;
  logic [15:0] rdat_q, rdat_d;
  logic        o_q, o_d;
  logic        oe_q, oe_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rdat_d = rdat_q;
    o_d    = o_q;
    oe_d   = oe_q;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      rd_d   = (cmd.op == MD_OP_READ);
      cnt_d  = '0;
      sh_d   = md_frame(cmd);
    end else if (busy_q && fall_tick) begin
      if (cnt_q == LAST_CNT) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        o_d    = 1'b1;
        oe_d   = 1'b0;
      end else begin
        o_d   = sh_q[63];
        sh_d  = {sh_q[62:0], 1'b1};
        oe_d  = !(rd_q && (cnt_q >= TA_CNT));
        cnt_d = cnt_q + 7'd1;
      end
    end
    if (busy_q && rise_tick && rd_q && (cnt_q >= RD_CNT)) begin
      rdat_d = {rdat_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
      rdat_q <= '0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rdat_q <= rdat_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rdata   = rdat_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer
  import phy_poll_pkg::*;
#(
  parameter int unsigned NPORT     = 5,
  parameter int unsigned BASE_ADDR = 8,
  parameter logic [15:0] ADV_WORD  = 16'h05E1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_en,
  input  logic             eng_done,
  input  logic [15:0]      eng_rdata,
  output logic             start,
  output md_cmd_t          cmd,
  output logic             idle,
  output logic [NPORT-1:0] link,
  output logic [NPORT-1:0] fast,
  output logic [NPORT-1:0] full,
  output logic [NPORT-1:0] pause
);
  localparam int unsigned PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [PW-1:0] LAST_PORT = PW'(NPORT - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_e;

  sq_e             st_q, st_d;
  logic [PW-1:0]   port_q, port_d;
  logic            step_q, step_d;
  logic            poll_q, poll_d;
  logic            lnk1_q, lnk1_d;
  logic [NPORT-1:0] link_q, link_d, fast_q, fast_d, full_q, full_d, pau_q, pau_d;
  logic            upd;
  port_res_t       res;

  always_comb begin
    st_d   = st_q;
    port_d = port_q;
    step_d = step_q;
    poll_d = poll_q;
    lnk1_d = lnk1_q;
    start  = 1'b0;
    upd    = 1'b0;
    unique case (st_q)
      SQ_IDLE:  if (poll_en) st_d = SQ_ISSUE;
      SQ_ISSUE: begin
        start = 1'b1;
        st_d  = SQ_WAIT;
      end
      SQ_WAIT: if (eng_done) begin
        if (poll_q && !step_q) lnk1_d = eng_rdata[2];
        if (poll_q && step_q)  upd = 1'b1;
        st_d   = SQ_ISSUE;
        step_d = ~step_q;
        if (step_q) begin
          if (port_q == LAST_PORT) begin
            port_d = '0;
            poll_d = 1'b1;
          end else begin
            port_d = port_q + PW'(1);
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    res    = md_resolve(ADV_WORD, lnk1_q, eng_rdata);
    link_d = link_q;
    fast_d = fast_q;
    full_d = full_q;
    pau_d  = pau_q;
    if (upd) begin
      link_d[port_q] = res.link;
      fast_d[port_q] = res.fast;
      full_d[port_q] = res.full;
      pau_d[port_q]  = res.pause;
    end
  end

  always_comb begin
    cmd.phy = 5'(BASE_ADDR) + 5'(port_q);
    unique case ({poll_q, step_q})
      2'b00: begin cmd.op = MD_OP_WRITE; cmd.regad = REG_ADV;  cmd.wdata = ADV_WORD;     end
      2'b01: begin cmd.op = MD_OP_WRITE; cmd.regad = REG_CTRL; cmd.wdata = ANEG_RESTART; end
      2'b10: begin cmd.op = MD_OP_READ;  cmd.regad = REG_STAT; cmd.wdata = 16'h0000;     end
      default: begin cmd.op = MD_OP_READ; cmd.regad = REG_LPA; cmd.wdata = 16'h0000;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      port_q <= '0;
      step_q <= 1'b0;
      poll_q <= 1'b0;
      lnk1_q <= 1'b0;
      link_q <= '0;
      fast_q <= '0;
      full_q <= '0;
      pau_q  <= '0;
    end else begin
      st_q   <= st_d;
      port_q <= port_d;
      step_q <= step_d;
      poll_q <= poll_d;
      lnk1_q <= lnk1_d;
      link_q <= link_d;
      fast_q <= fast_d;
      full_q <= full_d;
      pau_q  <= pau_d;
    end
  end

  assign idle  = (st_q == SQ_IDLE);
  assign link  = link_q;
  assign fast  = fast_q;
  assign full  = full_q;
  assign pause = pau_q;
endmodule

// File: rtl/mgmt_phy_poller.sv
module mgmt_phy_poller
  import phy_poll_pkg::*;
#(
  parameter int unsigned NPORT     = 5,
  parameter int unsigned HALF_DIV  = 10,
  parameter int unsigned PHY_BASE  = 8,
  parameter logic [15:0] ADV_WORD  = 16'h05E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_en,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic [15:0] pause_link,
  output logic [15:0] speed_duplex
);
  localparam int unsigned FIELD = 8;

  logic        rise_tick, fall_tick;
  logic        eng_start, eng_busy, eng_done, seq_idle;
  logic [15:0] eng_rdata;
  md_cmd_t     eng_cmd;
  logic [NPORT-1:0] st_link, st_fast, st_full, st_pause;

  mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(eng_start), .cmd(eng_cmd), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  poll_sequencer #(.NPORT(NPORT), .BASE_ADDR(PHY_BASE), .ADV_WORD(ADV_WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
    .eng_done(eng_done), .eng_rdata(eng_rdata),
    .start(eng_start), .cmd(eng_cmd), .idle(seq_idle),
    .link(st_link), .fast(st_fast), .full(st_full), .pause(st_pause)
  );

  always_comb begin
    pause_link   = '0;
    speed_duplex = '0;
    for (int p = 0; p < NPORT; p++) begin
      pause_link[p]         = st_pause[p];
      pause_link[FIELD+p]   = st_link[p];
      speed_duplex[p]       = st_fast[p];
      speed_duplex[FIELD+p] = st_full[p];
    end
  end
endmodule

// File: rtl/mgmt_phy_poller_chk.sv
module mgmt_phy_poller_chk #(
  parameter int unsigned HALF_DIV = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        poll_en,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] pause_link,
  input logic [15:0] speed_duplex,
  input logic        busy,
  input logic        seq_idle
);
  logic        mdc_q;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      gap_q <= '0;
    end else begin
      mdc_q <= mdc;
      if (mdc != mdc_q)        gap_q <= 16'd1;
      else if (gap_q != '1)    gap_q <= gap_q + 16'd1;
    end
  end

  // R6: each MDC phase lasts HALF_DIV clocks
  assert_mdc_half_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_q) |-> (gap_q == 16'(HALF_DIV)));

  // R6: pad outputs move only together with an MDC falling edge
  assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R5: the pad is released whenever no frame is in progress
  assert_release_between_frames_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R2: strap low keeps the bus silent
  assert_strap_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !poll_en) |=> (!mdio_oe && !busy));

  // R9: pause needs link and full duplex
  assert_pause_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_link[7:0] & ~(pause_link[15:8] & speed_duplex[15:8])) == 8'h00);

  // R7: speed and duplex are only reported with link up
  assert_rate_needs_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((speed_duplex[7:0] | speed_duplex[15:8]) & ~pause_link[15:8]) == 8'h00);
endmodule

bind mgmt_phy_poller mgmt_phy_poller_chk #(.HALF_DIV(HALF_DIV)) i_chk (
  .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .pause_link(pause_link), .speed_duplex(speed_duplex),
  .busy(eng_busy), .seq_idle(seq_idle)
);

// File: tb/test_mgmt_phy_poller.sv
module test_mgmt_phy_poller;
  localparam int NP = 5;
  localparam int HD = 2;
  localparam logic [15:0] ADV = 16'h05E1;
  localparam logic [15:0] UP = 16'h782D;
  localparam logic [15:0] DOWN = 16'h7809;

  logic clk = 1'b0, rst_n = 1'b0, poll_en = 1'b0, mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe;
  logic [15:0] pause_link, speed_duplex;

  always #2 clk = ~clk;

  mgmt_phy_poller #(.NPORT(NP), .HALF_DIV(HD), .PHY_BASE(8), .ADV_WORD(ADV)) i_mgmt_phy_poller (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .pause_link(pause_link), .speed_duplex(speed_duplex)
  );

  int n_checks = 0, n_fail = 0, frames_seen = 0, rounds_seen = 0;
  bit finished = 0;
  logic [15:0] r1_m [NP];
  logic [15:0] r5_m [NP];

  typedef struct packed { logic [1:0] op; logic [4:0] phy; logic [4:0] rg; logic [15:0] d; } exp_t;
  exp_t exp_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    exp_t e;
    e.op = op; e.phy = phy; e.rg = rg; e.d = d;
    exp_q.push_back(e);
  endtask

  // PHY model and monitor
  bit in_fr = 0;
  int pos = 0;
  logic [13:0] hdr;
  logic [15:0] wd, rv;
  bit pre_ok, fmt_ok;

  task automatic end_frame();
    exp_t e;
    frames_seen++;
    check("R5 preamble ones with pad driven", {31'd0, pre_ok}, 32'd1);
    check("R5 start code, turnaround and pad release", {30'd0, hdr[13:12], fmt_ok}, {30'd0, 2'b01, 1'b1});
    if (exp_q.size() == 0) begin
      n_checks++; n_fail++;
      $display("FAIL R4 unexpected frame actual=%h expected=none", hdr);
    end else begin
      e = exp_q.pop_front();
      if (e.op == 2'b01)
        check("R3 init write op/phy/reg/data", {hdr[11:0], wd}, {e.op, e.phy, e.rg, e.d});
      else
        check("R4 poll read op/phy/reg", {16'd0, hdr[11:0]}, {16'd0, e.op, e.phy, e.rg});
    end
    if (hdr[4:0] == 5'd5 && hdr[9:5] == 5'd12) rounds_seen++;
    in_fr = 0;
  endtask

  always @(posedge mdc) begin
    if (!in_fr) begin
      if (mdio_oe === 1'b1) begin
        in_fr = 1; pos = 1; pre_ok = (mdio_o === 1'b1); fmt_ok = 1; hdr = '0; wd = '0;
      end
    end else begin
      pos++;
      if (pos <= 32) pre_ok &= (mdio_o === 1'b1) && (mdio_oe === 1'b1);
      else if (pos <= 46) begin
        hdr = {hdr[12:0], mdio_o};
        if (pos == 46) begin
          if (hdr[9:5] >= 5'd8 && hdr[9:5] <= 5'd12)
            rv = (hdr[4:0] == 5'd1) ? r1_m[hdr[9:5]-5'd8] :
                 (hdr[4:0] == 5'd5) ? r5_m[hdr[9:5]-5'd8] : 16'hFFFF;
          else rv = 16'hFFFF;
        end
      end else begin
        if (hdr[11:10] == 2'b01) begin
          if (pos == 47) fmt_ok &= (mdio_o === 1'b1) && (mdio_oe === 1'b1);
          else if (pos == 48) fmt_ok &= (mdio_o === 1'b0) && (mdio_oe === 1'b1);
          else wd = {wd[14:0], mdio_o};
        end else begin
          fmt_ok &= (mdio_oe === 1'b0);
        end
      end
      if (pos == 64) end_frame();
    end
  end

  always @(negedge mdc) begin
    if (in_fr && pos >= 47 && pos <= 63 && hdr[11:10] == 2'b10)
      mdio_i = (pos == 47) ? 1'b0 : rv[63-pos];
    else
      mdio_i = 1'b1;
  end

  function automatic logic [3:0] exp_port(logic [15:0] r1, logic [15:0] r5); // {link,fast,full,pause}
    logic f, d;
    if (!r1[2]) return 4'b0000;
    f = 0; d = 0;
    if (ADV[8] && r5[8]) begin f = 1; d = 1; end
    else if (ADV[7] && r5[7]) f = 1;
    else if (ADV[6] && r5[6]) d = 1;
    return {1'b1, f, d, d & ADV[10] & r5[10]};
  endfunction

  task automatic check_status(string sc);
    logic [15:0] epl, esd;
    logic [3:0] x;
    epl = '0; esd = '0;
    for (int p = 0; p < NP; p++) begin
      x = exp_port(r1_m[p], r5_m[p]);
      epl[8+p] = x[3]; esd[p] = x[2]; esd[8+p] = x[1]; epl[p] = x[0];
    end
    check({"R7 link field ", sc}, {27'd0, pause_link[12:8]}, {27'd0, epl[12:8]});
    check({"R8 speed/duplex ", sc}, {16'd0, speed_duplex}, {16'd0, esd});
    check({"R9 pause field ", sc}, {27'd0, pause_link[4:0]}, {27'd0, epl[4:0]});
    check({"R10 packed words ", sc}, {pause_link, speed_duplex}, {epl, esd});
  endtask

  task automatic wait_rounds(int n);
    int base;
    base = rounds_seen;
    wait (rounds_seen >= base + n);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    longint t0, t1;
    for (int p = 0; p < NP; p++) begin r1_m[p] = DOWN; r5_m[p] = 16'h0000; end
    repeat (5) @(negedge clk);
    check("R1 reset words", {pause_link, speed_duplex}, 32'd0);
    check("R1 reset pad", {30'd0, mdio_oe, mdio_o}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {14'd0, mdio_oe, mdio_o, pause_link | speed_duplex}, {14'd0, 2'b01, 16'd0});
    repeat (600) @(negedge clk);
    check("R2 strap off no frames", frames_seen, 0);
    check("R2 strap off quiet", {15'd0, mdio_oe, pause_link | speed_duplex}, 32'd0);
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    check("R6 mdc high time in clocks", 32'((t1 - t0) / 4), HD);

    // scenario A
    r1_m[0] = UP; r5_m[0] = 16'h0501;
    r1_m[1] = UP; r5_m[1] = 16'h0481;
    r1_m[2] = UP; r5_m[2] = 16'h0041;
    r1_m[3] = UP; r5_m[3] = 16'h0021;
    r1_m[4] = DOWN; r5_m[4] = 16'h05E1;
    for (int p = 0; p < NP; p++) begin
      push_frame(2'b01, 5'(8 + p), 5'd4, ADV);
      push_frame(2'b01, 5'(8 + p), 5'd0, 16'h1200);
    end
    for (int r = 0; r < 40; r++)
      for (int p = 0; p < NP; p++) begin
        push_frame(2'b10, 5'(8 + p), 5'd1, 16'h0000);
        push_frame(2'b10, 5'(8 + p), 5'd5, 16'h0000);
      end
    poll_en = 1'b1;
    wait_rounds(2);
    check_status("A");

    // scenario B
    r1_m[0] = UP;   r5_m[0] = 16'h0461;
    r1_m[1] = UP;   r5_m[1] = 16'h0001;
    r1_m[2] = UP;   r5_m[2] = 16'h01E1;
    r1_m[3] = DOWN; r5_m[3] = 16'h05E1;
    r1_m[4] = UP;   r5_m[4] = 16'h05E1;
    wait_rounds(2);
    check_status("B");

    // scenario C: every link lost
    for (int p = 0; p < NP; p++) r1_m[p] = DOWN;
    wait_rounds(2);
    check_status("C");
    check("R7 all links down words", {pause_link, speed_duplex}, 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule